// File: doc/BRIEF.md
# Extended Interrupt Vector Router

The router gathers a bank of incoming interrupt vector lines and delivers each one to a chosen CPU and a chosen interrupt pin on that CPU. A rising edge on a line sets a pending latch for that vector. The latch stays set until software writes a 1 to its status bit. A pending vector whose enable bit is set drives exactly one output pin: the pin given by its route byte and its pin field. Each output pin is the OR of every pending, enabled vector that lands on it.

Route bytes are read in one of two ways, and a configuration bit picks the way at run time. In the compatible way, the upper nibble of a route byte names a node and the lower nibble is a one-hot mask over four CPUs of that node. In the encoded way, the whole byte is a binary CPU number. Pin fields also have two readings: a one-hot mask over four pins, or a binary number over sixteen pins. A read-only capability word tells software that both encodings exist. A configuration word selects them and resets to zero, so after reset the router uses the compatible bitmap decoding. Software is expected to clear a vector's enable before it rewrites that vector's route.

The register interface is a plain 32-bit bus. A write takes effect at the clock edge. The read data is combinational from the address.

Top module: `evr_router`

## Requirements
- R1: After reset, every enable, pending, route, pin and configuration bit is 0, and every output pin is low.
- R2: A vector's pending bit is set one clock after a 0-to-1 change on its input line. Holding the line high does not set the bit again. The bit latches whether or not the vector is enabled. Pending word k, at 0x1800 + 4k, holds vectors 32k to 32k+31, with vector v at bit v mod 32.
- R3: Writing a 1 to a pending bit clears it, and writing a 0 leaves it unchanged. If a rising edge and a clearing write fall in the same cycle, the bit ends up set.
- R4: Enable word k, at 0x1600 + 4k, holds the enables of vectors 32k to 32k+31, with vector v at bit v mod 32. A vector reaches an output only when it is both pending and enabled.
- R5: The route byte of vector v is bits [(v mod 4)*8 +: 8] of the word at 0x1C00 + (v with its two low bits cleared). The pin field of vector v is bits [(v mod 8)*4 +: 4] of the word at 0x1400 + 4*(v div 8). Both read back as written.
- R6: In bitmap CPU mode (configuration bit 3 = 0), a route byte reaches a local CPU only when bits [7:4] equal the node parameter. The CPU is the index of the lowest set bit in bits [3:0]. If bits [3:0] are all zero, the vector reaches no CPU.
- R7: In encoded CPU mode (configuration bit 3 = 1), the route byte is a binary CPU number. A number at or above the CPU count reaches no output.
- R8: In bitmap pin mode (configuration bit 2 = 0), the pin is the index of the lowest set bit in pin-field bits [3:0], so it is one of pins 0 to 3. An all-zero field reaches no pin. In encoded pin mode (configuration bit 2 = 1), the field is a binary pin number from 0 to 15.
- R9: The capability word at 0x40000000 always reads 0x0000000F. Writes to it change nothing.
- R10: The configuration word at 0x40000004 stores bits 1, 2 and 3. Its other bits read as 0.
- R11: A vector whose enable bit is clear drives no output, even while its route is rewritten. A route rewrite made while the vector is enabled moves the delivery in the next cycle.
- R12: Output bit c*16 + p is pin p of CPU c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | NUM_VEC | Incoming vector lines, sampled for rising edges |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 32 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i |
| irq_o | output | NUM_CPU*16 | Per-CPU pin outputs, CPU c pin p at bit c*16+p |

## Verification
The hardest case to reach from the ports is a route rewrite while the vector is pending. A rising edge must set the latch first. The enable must then be dropped without clearing the latch, the route rewritten, and the output watched both before and after the enable returns. The bench sets up this sequence explicitly. It also drives a rising edge and a clearing write in the same cycle to check which one wins. A full sweep in encoded mode spreads the 256 vectors across every CPU and pin, so each vector's route lane, pin nibble and enable bit is confirmed as a single output bit.

// File: rtl/evr_pkg.sv
// Package: shared register map, field positions and helper functions for
// the extended vector router. Assumes a 32-bit byte-addressed register bus.
package evr_pkg;
    localparam logic [31:0] PIN_BASE   = 32'h0000_1400;
    localparam logic [31:0] EN_BASE    = 32'h0000_1600;
    localparam logic [31:0] PEND_BASE  = 32'h0000_1800;
    localparam logic [31:0] ROUTE_BASE = 32'h0000_1C00;
    localparam logic [31:0] FEAT_ADDR  = 32'h4000_0000;
    localparam logic [31:0] CFG_ADDR   = 32'h4000_0004;
    localparam logic [31:0] FEAT_VALUE = 32'h0000_000F;
    localparam logic [31:0] CFG_MASK   = 32'h0000_000E;
    localparam int CFG_PIN_ENC = 2;
    localparam int CFG_CPU_ENC = 3;

    typedef struct packed {
        logic       hit;
        logic [7:0] cpu;
        logic [3:0] pin;
    } route_dec_t;

    // Byte address of the idx-th 32-bit word above base.
    function automatic logic [31:0] word_addr(input logic [31:0] base, input int idx);
        return base + (32'(idx) << 2);
    endfunction

    // Lowest set bit of a 4-bit mask: {found, index}.
    function automatic logic [2:0] lowest4(input logic [3:0] m);
        if (m[0]) return 3'b100;
        if (m[1]) return 3'b101;
        if (m[2]) return 3'b110;
        if (m[3]) return 3'b111;
        return 3'b000;
    endfunction
endpackage

// File: rtl/evr_pending.sv
// Pending latches: one per vector, set on a rising input edge and cleared by a
// write-one-to-clear strobe. Set has priority over clear in the same cycle.
module evr_pending #(
    parameter int NUM_VEC = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] irq_i,
    input  logic [NUM_VEC-1:0] clr_i,
    output logic [NUM_VEC-1:0] pend_o
);
    logic [NUM_VEC-1:0] irq_q;

    // Remember the previous line levels and update the latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q  <= '0;
            pend_o <= '0;
        end else begin
            irq_q  <= irq_i;
            pend_o <= (pend_o & ~clr_i) | (irq_i & ~irq_q);
        end
    end
endmodule

// File: rtl/evr_regs.sv
// Register file: enables, pin fields, route bytes and configuration, plus the
// read mux and the pending clear strobes. Assumes whole-word writes only.
module evr_regs
    import evr_pkg::*;
#(
    parameter int NUM_VEC = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_we_i,
    input  logic [31:0]            bus_addr_i,
    input  logic [31:0]            bus_wdata_i,
    output logic [31:0]            bus_rdata_o,
    input  logic [NUM_VEC-1:0]     pend_i,
    output logic [NUM_VEC-1:0]     clr_o,
    output logic [NUM_VEC-1:0]     en_o,
    output logic [NUM_VEC-1:0][7:0] route_o,
    output logic [NUM_VEC-1:0][3:0] pin_o,
    output logic [31:0]            cfg_o
);
    // Store writes to enables, pin fields, route bytes and configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o    <= '0;
            route_o <= '0;
            pin_o   <= '0;
            cfg_o   <= '0;
        end else if (bus_we_i) begin
            if (bus_addr_i == CFG_ADDR) cfg_o <= bus_wdata_i & CFG_MASK;
            for (int v = 0; v < NUM_VEC; v++) begin
                if (bus_addr_i == word_addr(EN_BASE, v / 32))
                    en_o[v] <= bus_wdata_i[v % 32];
                if (bus_addr_i == word_addr(ROUTE_BASE, v / 4))
                    route_o[v] <= bus_wdata_i[(v % 4) * 8 +: 8];
                if (bus_addr_i == word_addr(PIN_BASE, v / 8))
                    pin_o[v] <= bus_wdata_i[(v % 8) * 4 +: 4];
            end
        end
    end

    // Decode write-one-to-clear strobes for the pending latches.
    always_comb begin
        clr_o = '0;
        for (int v = 0; v < NUM_VEC; v++)
            if (bus_we_i && bus_addr_i == word_addr(PEND_BASE, v / 32))
                clr_o[v] = bus_wdata_i[v % 32];
    end

    // Select read data for the current address.
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == FEAT_ADDR) bus_rdata_o = FEAT_VALUE;
        if (bus_addr_i == CFG_ADDR)  bus_rdata_o = cfg_o;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (bus_addr_i == word_addr(EN_BASE, v / 32))
                bus_rdata_o[v % 32] = en_o[v];
            if (bus_addr_i == word_addr(PEND_BASE, v / 32))
                bus_rdata_o[v % 32] = pend_i[v];
            if (bus_addr_i == word_addr(ROUTE_BASE, v / 4))
                bus_rdata_o[(v % 4) * 8 +: 8] = route_o[v];
            if (bus_addr_i == word_addr(PIN_BASE, v / 8))
                bus_rdata_o[(v % 8) * 4 +: 4] = pin_o[v];
        end
    end
endmodule

// File: rtl/evr_deliver.sv
// Delivery: decodes each vector's route byte and pin field under the current
// mode bits and ORs every pending, enabled vector onto its CPU pin output.
module evr_deliver
    import evr_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int NUM_CPU = 4,
    parameter int NUM_PIN = 16,
    parameter int NODE_ID = 0
) (
    input  logic [NUM_VEC-1:0]        pend_i,
    input  logic [NUM_VEC-1:0]        en_i,
    input  logic [NUM_VEC-1:0][7:0]   route_i,
    input  logic [NUM_VEC-1:0][3:0]   pin_i,
    input  logic                      cpu_enc_i,
    input  logic                      pin_enc_i,
    output logic [NUM_CPU*NUM_PIN-1:0] irq_o
);
    localparam int NUM_OUT = NUM_CPU * NUM_PIN;

    // Turn one route byte and pin field into a target, or no target.
    function automatic route_dec_t decode(input logic [7:0] rb, input logic [3:0] pf,
                                          input logic cenc, input logic penc);
        route_dec_t d;
        logic [2:0] lc, lp;
        lc = lowest4(rb[3:0]);
        lp = lowest4(pf);
        d.hit = 1'b1;
        if (cenc) begin
            d.cpu = rb;
        end else begin
            d.cpu = {6'd0, lc[1:0]};
            if (int'(rb[7:4]) != NODE_ID || !lc[2]) d.hit = 1'b0;
        end
        if (int'(d.cpu) >= NUM_CPU) d.hit = 1'b0;
        if (penc) begin
            d.pin = pf;
        end else begin
            d.pin = {2'd0, lp[1:0]};
            if (!lp[2]) d.hit = 1'b0;
        end
        if (int'(d.pin) >= NUM_PIN) d.hit = 1'b0;
        return d;
    endfunction

    route_dec_t dec [NUM_VEC];

    for (genvar gv = 0; gv < NUM_VEC; gv++) begin : g_vec
        assign dec[gv] = decode(route_i[gv], pin_i[gv], cpu_enc_i, pin_enc_i);
    end

    // Gather the live vectors onto their output bits.
    always_comb begin
        irq_o = '0;
        for (int v = 0; v < NUM_VEC; v++)
            if (pend_i[v] && en_i[v] && dec[v].hit)
                irq_o[(int'(dec[v].cpu) * NUM_PIN + int'(dec[v].pin)) % NUM_OUT] = 1'b1;
    end
endmodule

// File: rtl/evr_router.sv
// Top: extended interrupt vector router. Wires the pending latches, register
// file and delivery network. Assumes irq_i is synchronous to clk.
module evr_router
    import evr_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int NUM_CPU = 4,
    parameter int NODE_ID = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_VEC-1:0]    irq_i,
    input  logic                  bus_we_i,
    input  logic [31:0]           bus_addr_i,
    input  logic [31:0]           bus_wdata_i,
    output logic [31:0]           bus_rdata_o,
    output logic [NUM_CPU*16-1:0] irq_o
);
    localparam int NUM_PIN = 16;

    logic [NUM_VEC-1:0]      pend_q;
    logic [NUM_VEC-1:0]      clr_w;
    logic [NUM_VEC-1:0]      en_q;
    logic [NUM_VEC-1:0][7:0] route_q;
    logic [NUM_VEC-1:0][3:0] pin_q;
    logic [31:0]             cfg_q;

    evr_pending #(.NUM_VEC(NUM_VEC)) u_pend (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .clr_i(clr_w), .pend_o(pend_q)
    );

    evr_regs #(.NUM_VEC(NUM_VEC)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .pend_i(pend_q),
        .clr_o(clr_w), .en_o(en_q), .route_o(route_q), .pin_o(pin_q), .cfg_o(cfg_q)
    );

    evr_deliver #(.NUM_VEC(NUM_VEC), .NUM_CPU(NUM_CPU), .NUM_PIN(NUM_PIN),
                  .NODE_ID(NODE_ID)) u_deliver (
        .pend_i(pend_q), .en_i(en_q), .route_i(route_q), .pin_i(pin_q),
        .cpu_enc_i(cfg_q[CFG_CPU_ENC]), .pin_enc_i(cfg_q[CFG_PIN_ENC]), .irq_o(irq_o)
    );
endmodule

// File: rtl/evr_router_chk.sv
// Checker: temporal properties of the router, bound to every evr_router.
module evr_router_chk
    import evr_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int NUM_CPU = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_VEC-1:0]    irq_i,
    input logic                  bus_we_i,
    input logic [31:0]           bus_addr_i,
    input logic [31:0]           bus_wdata_i,
    input logic [31:0]           bus_rdata_o,
    input logic [NUM_CPU*16-1:0] irq_o,
    input logic [NUM_VEC-1:0]    pend_q,
    input logic [NUM_VEC-1:0]    en_q
);
    for (genvar gv = 0; gv < NUM_VEC; gv++) begin : g_chk
        p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_i[gv]) |=> pend_q[gv]);
    end

    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == PEND_BASE && bus_wdata_i[0] && !irq_i[0]) |=> !pend_q[0]);

    p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & en_q) == '0) |-> (irq_o == '0));

    p_feat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == FEAT_ADDR) |-> (bus_rdata_o == 32'h0000_000F));

    p_cfg_rsvd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == CFG_ADDR) |-> ((bus_rdata_o & 32'hFFFF_FFF1) == '0));

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0));
endmodule

bind evr_router evr_router_chk #(.NUM_VEC(NUM_VEC), .NUM_CPU(NUM_CPU)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .irq_o(irq_o), .pend_q(pend_q), .en_q(en_q)
);

// File: tb/evr_router_tb_top.sv
// Bench: sweeps every vector in encoded mode and walks the bitmap decoding,
// pending and enable corner cases. Inputs change on falling edges.
module evr_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 256;
    localparam int NC = 4;
    localparam int NO = NC * 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NV-1:0] irq = '0;
    logic          we = 1'b0;
    logic [31:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NO-1:0] irq_o;
    int checks = 0;
    int errors = 0;

    evr_router #(.NUM_VEC(NV), .NUM_CPU(NC), .NODE_ID(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input int v);
        @(negedge clk); irq[v] = 1'b1;
        @(negedge clk); irq[v] = 1'b0;
    endtask

    function automatic logic [63:0] onebit(input int b);
        return 64'd1 << b;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 outputs", irq_o, 64'd0);
        rd(32'h4000_0004, r); chk("R1 cfg", r, 0);
        rd(32'h0000_1600, r); chk("R1 enable", r, 0);
        rd(32'h0000_1C00, r); chk("R1 route", r, 0);

        // R9: capability word fixed
        rd(32'h4000_0000, r); chk("R9 read", r, 32'hF);
        wr(32'h4000_0000, 32'h0);
        rd(32'h4000_0000, r); chk("R9 write ignored", r, 32'hF);

        // R10: configuration storage mask
        wr(32'h4000_0004, 32'hFFFF_FFFF);
        rd(32'h4000_0004, r); chk("R10 mask", r, 32'hE);

        // R5: route and pin readback
        wr(32'h0000_1C04, 32'h4433_2211);
        rd(32'h0000_1C04, r); chk("R5 route", r, 32'h4433_2211);
        wr(32'h0000_1408, 32'h8765_4321);
        rd(32'h0000_1408, r); chk("R5 pin", r, 32'h8765_4321);

        // Encoded sweep: vector v -> CPU v%4, pin v%16 (R7 R8 R12 R4 R3)
        wr(32'h4000_0004, 32'hC);
        for (int w = 0; w < NV / 4; w++) wr(32'h1C00 + w * 4, 32'h0302_0100);
        for (int w = 0; w < NV / 8; w++)
            wr(32'h1400 + w * 4, (w % 2 == 0) ? 32'h7654_3210 : 32'hFEDC_BA98);
        for (int w = 0; w < NV / 32; w++) wr(32'h1600 + w * 4, 32'hFFFF_FFFF);
        for (int v = 0; v < NV; v++) begin
            pulse(v);
            chk("R7 R8 R12 sweep", irq_o, onebit((v % 4) * 16 + (v % 16)));
            wr(32'h1800 + (v / 32) * 4, 32'd1 << (v % 32));
            chk("R3 clear", irq_o, 64'd0);
        end

        // R7: CPU number beyond count
        wr(32'h0000_1C04, 32'h0000_C800);
        pulse(5);
        chk("R7 out of range", irq_o, 64'd0);
        rd(32'h0000_1800, r); chk("R2 pending read", r, 32'h20);

        // R6 R8: bitmap decode, vector 5 pending
        wr(32'h4000_0004, 32'h0);
        wr(32'h0000_1400, 32'h00C0_0000);
        wr(32'h0000_1C04, 32'h0000_0600);
        chk("R6 R8 bitmap lowest", irq_o, onebit(1 * 16 + 2));
        wr(32'h0000_1C04, 32'h0000_1600);
        chk("R6 node mismatch", irq_o, 64'd0);
        wr(32'h0000_1C04, 32'h0000_0000);
        chk("R6 empty mask", irq_o, 64'd0);
        wr(32'h0000_1C04, 32'h0000_0800);
        chk("R6 cpu3", irq_o, onebit(3 * 16 + 2));
        wr(32'h0000_1400, 32'h0000_0000);
        chk("R8 empty pin", irq_o, 64'd0);
        wr(32'h0000_1400, 32'h0080_0000);
        chk("R8 pin3", irq_o, onebit(3 * 16 + 3));

        // R11: disabled vector stays silent across a route rewrite
        wr(32'h0000_1600, 32'hFFFF_FFDF);
        chk("R11 disabled", irq_o, 64'd0);
        wr(32'h0000_1C04, 32'h0000_0100);
        chk("R11 rewrite disabled", irq_o, 64'd0);
        rd(32'h0000_1800, r); chk("R11 still pending", r, 32'h20);
        wr(32'h0000_1600, 32'hFFFF_FFFF);
        chk("R11 reenable", irq_o, onebit(0 * 16 + 3));
        wr(32'h0000_1C04, 32'h0000_0200);
        chk("R11 live rewrite", irq_o, onebit(1 * 16 + 3));
        wr(32'h0000_1800, 32'h20);

        // R4: pending but disabled latch does not output
        wr(32'h0000_1600, 32'h0);
        pulse(5);
        chk("R4 disabled pending", irq_o, 64'd0);
        rd(32'h0000_1800, r); chk("R2 latched while disabled", r, 32'h20);
        wr(32'h0000_1600, 32'h20);
        chk("R4 enabled", irq_o, onebit(1 * 16 + 3));
        wr(32'h0000_1800, 32'h0);
        rd(32'h0000_1800, r); chk("R3 zero write keeps", r, 32'h20);
        wr(32'h0000_1800, 32'h20);

        // R2: level held high does not re-set after clear
        @(negedge clk); irq[6] = 1'b1;
        @(negedge clk);
        wr(32'h0000_1800, 32'h40);
        repeat (3) @(negedge clk);
        rd(32'h0000_1800, r); chk("R2 level no reset", r, 32'h0);
        irq[6] = 1'b0;

        // R3: edge and clear in the same cycle, set wins
        @(negedge clk);
        irq[7] = 1'b1; we = 1'b1; addr = 32'h1800; wdata = 32'h80;
        @(negedge clk);
        we = 1'b0; irq[7] = 1'b0;
        rd(32'h0000_1800, r); chk("R3 set wins", r, 32'h80);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule